// File: doc/BRIEF.md
# Maskable Interrupt Entry and Return Sequencer

This block sits at the instruction boundary of a small 16-bit segmented processor, between the execution core and its word-wide memory port. Each time the core finishes an instruction it pulses a boundary strobe. The block then decides whether a pending maskable interrupt is taken. The request must be present and the interrupt-enable bit of the status word must be set.

When an interrupt is taken, the block performs the entry sequence. It saves the status word, the code segment and the instruction pointer on a downward-growing stack and masks further interrupts and single-stepping. It then obtains an 8-bit vector number from the interrupt controller through an acknowledge handshake. Finally it reads that vector's 4-byte entry from the table and loads the new code segment and instruction pointer. The return sequence is the inverse: it pops the three saved words and restores them.

The status word, code segment and instruction pointer live inside the block. The stack segment and stack pointer come in as ports, and the updated stack pointer goes out with a one-cycle update strobe. While a sequence runs, a busy output holds the core off fetching.

Top module: `irq_entry_seq`

## Requirements
- R1: An interrupt is accepted only in a cycle where `instr_done` is 1, `irq_req` is 1 and status bit 9 (interrupt enable) is 1. In every other case `busy` stays 0 and no memory write occurs.
- R2: `busy` rises in the cycle after acceptance. It falls in the same cycle that the final code segment, instruction pointer and status values become visible.
- R3: Entry pushes three words, each at physical address SS*16 + (SP-2) with SP decremented by 2 before each write. The order is status, then code segment, then instruction pointer. `sp_o` ends at SP-6 with `sp_upd` pulsed.
- R4: The pushed status word is the value before entry. Once that push completes, bits 9 (interrupt enable) and 8 (trap) of the live status word are 0, and they remain 0 for the rest of the entry.
- R5: After the three pushes, `irq_ack` is 1 and the block waits with `busy` high until `ack_valid`. At that point it latches `ack_vec`.
- R6: For vector number N, the word at byte address N*4 is loaded into the instruction pointer and the word at N*4+2 into the code segment. Each word has its low byte at the lower address.
- R7: A boundary with `ret_req` pops three words at SS*16+SP, adding 2 to SP after each. The order is instruction pointer, code segment, status. All three registers are restored and `sp_o` ends at SP+6.
- R8: While `mem_ready` is 0, the block holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged, writes nothing and does not advance.
- R9: When `ret_req` and a takeable `irq_req` arrive at the same boundary, the return is performed first, so the first access is a read.
- R10: `arch_we` loads the three registers from `arch_*_i` in the next cycle when idle. While `busy` is 1 it has no effect.
- R11: After reset the status word is 16'h0002, the code segment 16'hF000 and the instruction pointer 16'hFFF0. `busy`, `irq_ack` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Instruction-boundary strobe from the core |
| irq_req | input | 1 | Maskable interrupt request level |
| ret_req | input | 1 | Return-from-interrupt request at the boundary |
| busy | output | 1 | Sequence in progress; core must not fetch |
| arch_we | input | 1 | Core write of status, code segment and pointer |
| arch_status_i | input | 16 | Status word to load |
| arch_cs_i | input | 16 | Code segment to load |
| arch_ip_i | input | 16 | Instruction pointer to load |
| status_o | output | 16 | Live status word |
| cs_o | output | 16 | Live code segment |
| ip_o | output | 16 | Live instruction pointer |
| ss_i | input | 16 | Stack segment |
| sp_i | input | 16 | Stack pointer at sequence start |
| sp_o | output | 16 | Working / final stack pointer |
| sp_upd | output | 1 | One-cycle strobe: `sp_o` holds the new stack pointer |
| irq_ack | output | 1 | Acknowledge request to the interrupt controller |
| ack_valid | input | 1 | Controller presents the vector number |
| ack_vec | input | 8 | Vector number |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical byte address (even) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when `mem_ready` |
| mem_ready | input | 1 | Access completes this cycle |

## Verification
The bench tries entry and return under four operand sets. These combine zero and non-zero stack segments, a stack pointer near a segment top, vectors 0, 8, 28 and 255, and status words with and without the trap bit. Some sets run with a memory that is always ready and some with one that is ready on alternate cycles. This separates push ordering and address arithmetic from the stall handling. Directed cases cover a masked request, a request without a boundary, simultaneous return and interrupt, a held-off acknowledge, a forced long stall, and a core write attempted mid-sequence. Each of these exposes a different wrong decision at the boundary or a leak of state.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH_ST,
    S_PUSH_CS,
    S_PUSH_IP,
    S_ACK,
    S_VEC_LO,
    S_VEC_HI,
    S_POP_IP,
    S_POP_CS,
    S_POP_ST
  } seq_state_t;

  localparam int unsigned TRAP_BIT = 8;
  localparam int unsigned IEN_BIT  = 9;

endpackage

// File: rtl/irq_addr_gen.sv
module irq_addr_gen #(
  parameter int unsigned W      = 16,
  parameter int unsigned ADDR_W = 20
) (
  input  logic [W-1:0]      seg,
  input  logic [W-1:0]      off,
  output logic [ADDR_W-1:0] phys
);
  localparam int unsigned SHIFT = ADDR_W - W;

  // segment * 16 + offset, wrapping at the top of the address space
  assign phys = {seg, {SHIFT{1'b0}}} + ADDR_W'(off);

endmodule

// File: rtl/irq_arch_regs.sv
module irq_arch_regs
  import irq_seq_pkg::*;
#(
  parameter int unsigned W          = 16,
  parameter logic [W-1:0] RST_STATUS = 16'h0002,
  parameter logic [W-1:0] RST_CS     = 16'hF000,
  parameter logic [W-1:0] RST_IP     = 16'hFFF0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_we,
  input  logic [W-1:0] ext_status,
  input  logic [W-1:0] ext_cs,
  input  logic [W-1:0] ext_ip,
  input  logic         mask_clr,
  input  logic         ld_vec,
  input  logic         ld_ret,
  input  logic [W-1:0] seq_status,
  input  logic [W-1:0] seq_cs,
  input  logic [W-1:0] seq_ip,
  output logic [W-1:0] status_q,
  output logic [W-1:0] cs_q,
  output logic [W-1:0] ip_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= RST_STATUS;
      cs_q     <= RST_CS;
      ip_q     <= RST_IP;
    end else if (ld_ret) begin
      status_q <= seq_status;
      cs_q     <= seq_cs;
      ip_q     <= seq_ip;
    end else if (ld_vec) begin
      cs_q <= seq_cs;
      ip_q <= seq_ip;
    end else if (mask_clr) begin
      status_q[IEN_BIT]  <= 1'b0;
      status_q[TRAP_BIT] <= 1'b0;
    end else if (ext_we) begin
      status_q <= ext_status;
      cs_q     <= ext_cs;
      ip_q     <= ext_ip;
    end
  end

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int unsigned  W       = 16,
  parameter int unsigned  VEC_W   = 8,
  parameter logic [W-1:0] VEC_SEG = 16'h0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_done,
  input  logic             irq_req,
  input  logic             ret_req,
  input  logic             ien,
  input  logic [W-1:0]     status_i,
  input  logic [W-1:0]     cs_i,
  input  logic [W-1:0]     ip_i,
  input  logic [W-1:0]     ss_i,
  input  logic [W-1:0]     sp_i,
  input  logic             ack_valid,
  input  logic [VEC_W-1:0] ack_vec,
  input  logic             mem_ready,
  input  logic [W-1:0]     mem_rdata,
  output seq_state_t       state,
  output logic             busy,
  output logic             irq_ack,
  output logic             mem_req,
  output logic             mem_we,
  output logic [W-1:0]     mem_wdata,
  output logic [W-1:0]     seg_o,
  output logic [W-1:0]     off_o,
  output logic [W-1:0]     sp_o,
  output logic             sp_upd,
  output logic             mask_clr,
  output logic             ld_vec,
  output logic             ld_ret,
  output logic [W-1:0]     new_status,
  output logic [W-1:0]     new_cs,
  output logic [W-1:0]     new_ip
);
  localparam logic [W-1:0] STEP = W'(2);
  localparam int unsigned  PAD  = W - VEC_W - 2;

  logic [W-1:0]     sp_w, ss_w, tmp_ip, tmp_cs;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      busy   <= 1'b0;
      sp_w   <= '0;
      ss_w   <= '0;
      tmp_ip <= '0;
      tmp_cs <= '0;
      vec_q  <= '0;
      sp_upd <= 1'b0;
    end else begin
      sp_upd <= 1'b0;
      unique case (state)
        S_IDLE: if (instr_done) begin
          if (ret_req) begin
            state <= S_POP_IP;
            busy  <= 1'b1;
            sp_w  <= sp_i;
            ss_w  <= ss_i;
          end else if (irq_req && ien) begin
            state <= S_PUSH_ST;
            busy  <= 1'b1;
            sp_w  <= sp_i;
            ss_w  <= ss_i;
          end
        end
        S_PUSH_ST: if (mem_ready) begin
          sp_w  <= sp_w - STEP;
          state <= S_PUSH_CS;
        end
        S_PUSH_CS: if (mem_ready) begin
          sp_w  <= sp_w - STEP;
          state <= S_PUSH_IP;
        end
        S_PUSH_IP: if (mem_ready) begin
          sp_w  <= sp_w - STEP;
          state <= S_ACK;
        end
        S_ACK: if (ack_valid) begin
          vec_q <= ack_vec;
          state <= S_VEC_LO;
        end
        S_VEC_LO: if (mem_ready) begin
          tmp_ip <= mem_rdata;
          state  <= S_VEC_HI;
        end
        S_VEC_HI: if (mem_ready) begin
          state  <= S_IDLE;
          busy   <= 1'b0;
          sp_upd <= 1'b1;
        end
        S_POP_IP: if (mem_ready) begin
          tmp_ip <= mem_rdata;
          sp_w   <= sp_w + STEP;
          state  <= S_POP_CS;
        end
        S_POP_CS: if (mem_ready) begin
          tmp_cs <= mem_rdata;
          sp_w   <= sp_w + STEP;
          state  <= S_POP_ST;
        end
        S_POP_ST: if (mem_ready) begin
          sp_w   <= sp_w + STEP;
          state  <= S_IDLE;
          busy   <= 1'b0;
          sp_upd <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    seg_o     = ss_w;
    off_o     = sp_w;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (state)
      S_PUSH_ST: begin mem_req = 1'b1; mem_we = 1'b1; off_o = sp_w - STEP; mem_wdata = status_i; end
      S_PUSH_CS: begin mem_req = 1'b1; mem_we = 1'b1; off_o = sp_w - STEP; mem_wdata = cs_i; end
      S_PUSH_IP: begin mem_req = 1'b1; mem_we = 1'b1; off_o = sp_w - STEP; mem_wdata = ip_i; end
      S_VEC_LO:  begin mem_req = 1'b1; seg_o = VEC_SEG; off_o = {{PAD{1'b0}}, vec_q, 2'b00}; end
      S_VEC_HI:  begin mem_req = 1'b1; seg_o = VEC_SEG; off_o = {{PAD{1'b0}}, vec_q, 2'b10}; end
      S_POP_IP, S_POP_CS, S_POP_ST: mem_req = 1'b1;
      default: ;
    endcase
  end

  assign irq_ack    = (state == S_ACK);
  assign sp_o       = sp_w;
  assign mask_clr   = (state == S_PUSH_ST) && mem_ready;
  assign ld_vec     = (state == S_VEC_HI) && mem_ready;
  assign ld_ret     = (state == S_POP_ST) && mem_ready;
  assign new_status = mem_rdata;
  assign new_cs     = ld_ret ? tmp_cs : mem_rdata;
  assign new_ip     = tmp_ip;

  // R1: a masked request at a boundary starts nothing
  p_masked_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && instr_done && !ret_req && !ien) |=> !busy);

  // R1: no memory traffic outside a sequence
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R3: every completed push lowers the stack pointer by one word
  p_push_step_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ready) |=> (sp_o == $past(sp_o) - STEP));

  // R5: acknowledge only inside a running sequence
  p_ack_in_seq_r5: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> busy);

  // R8: a waiting access keeps its request stable
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(seg_o)
                                 && $stable(off_o) && $stable(mem_wdata)));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int unsigned  W          = 16,
  parameter int unsigned  ADDR_W     = 20,
  parameter int unsigned  VEC_W      = 8,
  parameter logic [W-1:0] VEC_SEG    = 16'h0000,
  parameter logic [W-1:0] RST_STATUS = 16'h0002,
  parameter logic [W-1:0] RST_CS     = 16'hF000,
  parameter logic [W-1:0] RST_IP     = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_done,
  input  logic              irq_req,
  input  logic              ret_req,
  output logic              busy,
  input  logic              arch_we,
  input  logic [W-1:0]      arch_status_i,
  input  logic [W-1:0]      arch_cs_i,
  input  logic [W-1:0]      arch_ip_i,
  output logic [W-1:0]      status_o,
  output logic [W-1:0]      cs_o,
  output logic [W-1:0]      ip_o,
  input  logic [W-1:0]      ss_i,
  input  logic [W-1:0]      sp_i,
  output logic [W-1:0]      sp_o,
  output logic              sp_upd,
  output logic              irq_ack,
  input  logic              ack_valid,
  input  logic [VEC_W-1:0]  ack_vec,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [W-1:0]      mem_wdata,
  input  logic [W-1:0]      mem_rdata,
  input  logic              mem_ready
);

  seq_state_t   fsm_state;
  logic [W-1:0] seg_w, off_w, nst, ncs, nip;
  logic         mask_clr, ld_vec, ld_ret;

  irq_seq_fsm #(.W(W), .VEC_W(VEC_W), .VEC_SEG(VEC_SEG)) u_fsm (
    .clk(clk), .rst(rst), .instr_done(instr_done), .irq_req(irq_req),
    .ret_req(ret_req), .ien(status_o[IEN_BIT]), .status_i(status_o),
    .cs_i(cs_o), .ip_i(ip_o), .ss_i(ss_i), .sp_i(sp_i),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .state(fsm_state), .busy(busy), .irq_ack(irq_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .seg_o(seg_w), .off_o(off_w), .sp_o(sp_o), .sp_upd(sp_upd),
    .mask_clr(mask_clr), .ld_vec(ld_vec), .ld_ret(ld_ret),
    .new_status(nst), .new_cs(ncs), .new_ip(nip)
  );

  irq_arch_regs #(.W(W), .RST_STATUS(RST_STATUS), .RST_CS(RST_CS), .RST_IP(RST_IP)) u_regs (
    .clk(clk), .rst(rst), .ext_we(arch_we && !busy),
    .ext_status(arch_status_i), .ext_cs(arch_cs_i), .ext_ip(arch_ip_i),
    .mask_clr(mask_clr), .ld_vec(ld_vec), .ld_ret(ld_ret),
    .seq_status(nst), .seq_cs(ncs), .seq_ip(nip),
    .status_q(status_o), .cs_q(cs_o), .ip_q(ip_o)
  );

  irq_addr_gen #(.W(W), .ADDR_W(ADDR_W)) u_addr (
    .seg(seg_w), .off(off_w), .phys(mem_addr)
  );

  // R4: once the status push is done, enable and trap stay clear through entry
  p_mask_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (fsm_state inside {S_PUSH_CS, S_PUSH_IP, S_ACK, S_VEC_LO, S_VEC_HI})
      |-> (!status_o[IEN_BIT] && !status_o[TRAP_BIT]));

  // R10: a core write during a sequence leaves the code segment alone until the vector load
  p_ext_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !ld_vec && !ld_ret) |=> $stable(cs_o));

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] st, cs, ip, ss, sp;
    logic [7:0]  vec;
    logic [15:0] voff, vseg;
    logic        stall;
  } case_t;

  localparam case_t TBL [4] = '{
    '{16'h0202, 16'h1234, 16'h0100, 16'h0000, 16'h0600, 8'h08, 16'hAAA0, 16'hF000, 1'b0},
    '{16'h0302, 16'h2000, 16'hFFFE, 16'h0040, 16'h0300, 8'h1C, 16'h1234, 16'h5678, 1'b1},
    '{16'hFFD7, 16'hBEEF, 16'h0001, 16'h0000, 16'h07F0, 8'hFF, 16'h0BAD, 16'hC0DE, 1'b0},
    '{16'h0200, 16'h0000, 16'h0000, 16'h0070, 16'h0010, 8'h00, 16'h4321, 16'h8765, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic instr_done = 0, irq_req = 0, ret_req = 0, arch_we = 0;
  logic [15:0] a_st = 0, a_cs = 0, a_ip = 0, ss_i = 0, sp_i = 0;
  logic busy, sp_upd, irq_ack, ack_valid, mem_req, mem_we, mem_ready;
  logic [15:0] status_o, cs_o, ip_o, sp_o, mem_wdata, mem_rdata;
  logic [19:0] mem_addr;
  logic [7:0]  cur_vec = 0;
  logic ack_en = 1, stall_mode = 0, ready_force = 0;
  logic [15:0] mem [0:1023];
  int cyc = 0, wr_cnt = 0, checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ack_valid = irq_ack & ack_en;
  assign mem_ready = !ready_force && (!stall_mode || cyc[0]);
  assign mem_rdata = mem[mem_addr[10:1]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_we && mem_ready) begin
      mem[mem_addr[10:1]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  irq_entry_seq dut_i (
    .clk(clk), .rst(rst), .instr_done(instr_done), .irq_req(irq_req),
    .ret_req(ret_req), .busy(busy), .arch_we(arch_we), .arch_status_i(a_st),
    .arch_cs_i(a_cs), .arch_ip_i(a_ip), .status_o(status_o), .cs_o(cs_o),
    .ip_o(ip_o), .ss_i(ss_i), .sp_i(sp_i), .sp_o(sp_o), .sp_upd(sp_upd),
    .irq_ack(irq_ack), .ack_valid(ack_valid), .ack_vec(cur_vec),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_arch(input logic [15:0] st, cs, ip);
    a_st = st; a_cs = cs; a_ip = ip; arch_we = 1;
    @(negedge clk); arch_we = 0;
  endtask

  task automatic boundary(input logic irq, input logic ret);
    instr_done = 1; irq_req = irq; ret_req = ret;
    @(negedge clk); instr_done = 0; irq_req = 0; ret_req = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [9:0] widx(input logic [15:0] ss, input logic [15:0] off);
    logic [19:0] p;
    p = {ss, 4'b0} + 20'(off);
    return p[10:1];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w0;
    for (int i = 0; i < 1024; i++) mem[i] = 16'hDEAD;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 status", status_o, 16'h0002);
    chk("R11 cs", cs_o, 16'hF000);
    chk("R11 ip", ip_o, 16'hFFF0);
    chk("R11 busy/ack/req", {busy, irq_ack, mem_req}, 0);

    // table-driven entry and return
    for (int k = 0; k < 4; k++) begin
      case_t c;
      c = TBL[k];
      load_arch(c.st, c.cs, c.ip);
      chk("R10 arch load", {status_o, cs_o, ip_o}, {c.st, c.cs, c.ip});
      mem[{c.vec, 1'b0}] = c.voff;
      mem[{c.vec, 1'b1}] = c.vseg;
      ss_i = c.ss; sp_i = c.sp; cur_vec = c.vec; stall_mode = c.stall;
      w0 = wr_cnt;
      boundary(1, 0);
      chk("R2 busy rises", busy, 1);
      wait_idle();
      chk("R4 mask cleared", status_o, c.st & ~16'h0300);
      chk("R6 ip from vector", ip_o, c.voff);
      chk("R6 cs from vector", cs_o, c.vseg);
      chk("R3 sp after entry", sp_o, c.sp - 16'd6);
      chk("R3 pushed status", mem[widx(c.ss, c.sp - 16'd2)], c.st);
      chk("R3 pushed cs", mem[widx(c.ss, c.sp - 16'd4)], c.cs);
      chk("R3 pushed ip", mem[widx(c.ss, c.sp - 16'd6)], c.ip);
      chk("R3 write count", wr_cnt - w0, 3);
      sp_i = c.sp - 16'd6;
      boundary(0, 1);
      wait_idle();
      chk("R7 restored", {status_o, cs_o, ip_o}, {c.st, c.cs, c.ip});
      chk("R7 sp after return", sp_o, c.sp);
      stall_mode = 0;
    end

    // R1 masked request
    load_arch(16'h0002, 16'h1000, 16'h0200);
    ss_i = 0; sp_i = 16'h0600; w0 = wr_cnt;
    boundary(1, 0);
    chk("R1 masked busy", busy, 0);
    @(negedge clk);
    chk("R1 masked writes", wr_cnt - w0, 0);

    // R1 request without boundary
    load_arch(16'h0202, 16'h1000, 16'h0200);
    irq_req = 1;
    repeat (3) @(negedge clk);
    irq_req = 0;
    chk("R1 no boundary busy", busy, 0);
    chk("R1 no boundary writes", wr_cnt - w0, 0);

    // R9 return wins over interrupt
    mem[10'h280] = 16'h1111; mem[10'h281] = 16'h2222; mem[10'h282] = 16'h0246;
    sp_i = 16'h0500;
    boundary(1, 1);
    chk("R9 first access is read", {mem_req, mem_we}, 2'b10);
    wait_idle();
    chk("R9 restored", {status_o, cs_o, ip_o}, {16'h0246, 16'h2222, 16'h1111});
    chk("R9 sp", sp_o, 16'h0506);

    // R8 forced stall, R5 held acknowledge, R10 write ignored while busy
    load_arch(16'h0302, 16'h3333, 16'h4444);
    mem[10'h014] = 16'h5555; mem[10'h015] = 16'h6666; cur_vec = 8'h0A;
    sp_i = 16'h0600; ready_force = 1; ack_en = 0; w0 = wr_cnt;
    boundary(1, 0);
    chk("R8 req under stall", {mem_req, mem_we, mem_addr}, {2'b11, 20'h005FE});
    repeat (4) @(negedge clk);
    chk("R8 held addr", {mem_req, mem_we, mem_addr, mem_wdata}, {2'b11, 20'h005FE, 16'h0302});
    chk("R8 no write", wr_cnt - w0, 0);
    ready_force = 0;
    for (int i = 0; i < 10; i++) begin
      if (irq_ack) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R5 ack held", {irq_ack, busy}, 2'b11);
    chk("R5 pushes before ack", wr_cnt - w0, 3);
    load_arch(16'hFFFF, 16'h0BAD, 16'h0BAD);
    ack_en = 1;
    wait_idle();
    chk("R10 ignored while busy", {status_o, cs_o, ip_o}, {16'h0002, 16'h6666, 16'h5555});

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule